// File: doc/BRIEF.md
# Interrupt redirection controller

This block routes up to 24 raw interrupt lines into a stream of delivery requests. Each line has a redirection entry that software programs through a two-step access path. The path has an index register and a 32-bit data window on the same port pair. An entry holds an 8-bit vector, a 3-bit delivery-mode field (stored only), a trigger mode (edge or level), a mask bit and a read-only remote-pending flag. The block also provides an identification register, a read-only version register and an arbitration register. The arbitration register tracks the identification value.

Edge lines latch one request per low-to-high transition. Level lines are delivered while they are high. A delivered level line stays blocked until an end-of-interrupt (EOI) notice with its vector arrives. If the line is still high and unmasked at that point, it is delivered again. The controller offers one request at a time with a valid/ready handshake, and the lowest-numbered ready line goes first. Destination routing and message transport belong to the consumer of the request stream.

Top module: `irq_router`

## Requirements
- R1: Register index 0x00 (ID) reads 0 after reset. Only bits 27:24 take written values; all other bits read 0.
- R2: Register index 0x01 (version) reads 0x00170011 for 24 lines (bits 7:0 = 0x11, bits 23:16 = lines-1), and writes to it change nothing.
- R3: Register index 0x02 (arbitration) reads its 4-bit value in bits 27:24. That value is loaded with bits 27:24 of every ID write, and writes aimed at index 0x02 change nothing.
- R4: With `acc_sel`=0 the port reads and writes the 8-bit index. Line n's low word is at index 0x10+2n, with fields vector 7:0, delivery mode 10:8, remote-pending 14 (read-only), trigger 15 (1 = level) and mask 16. The high word at 0x11+2n reads 0 and ignores writes. After reset every low word reads 0x00010000, so all lines are masked.
- R5: An unmasked edge-triggered line produces exactly one delivery, with `dlv_level`=0, per low-to-high transition, however long it stays high.
- R6: An unmasked level-triggered line that is high and has remote-pending clear is delivered with `dlv_level`=1. The delivery sets remote-pending, and no further delivery of that line occurs while the flag is set.
- R7: An EOI whose vector matches an entry clears that entry's remote-pending flag, so a still-high unmasked level line is delivered again. An EOI with a non-matching vector has no effect.
- R8: Dropping and re-raising a level line before its EOI adds no delivery; the requests coalesce into the single EOI-driven re-delivery.
- R9: A rising edge seen while the line is masked is discarded and never delivered after unmasking. Writing the entry with mask=1 also discards an edge request not yet delivered.
- R10: A level line held high while masked is delivered once the mask is cleared. This includes the case where the EOI arrived while the line was masked.
- R11: When several lines are ready, the lowest-numbered one is offered, with at most one delivery per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 24 | Raw interrupt lines, bit n is line n |
| acc_sel | input | 1 | 0 selects the index register, 1 the data window |
| acc_wr | input | 1 | Write strobe for the selected register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected register |
| dlv_valid | output | 1 | A delivery request is offered |
| dlv_ready | input | 1 | The consumer takes the offered request this cycle |
| dlv_vector | output | 8 | Vector of the offered request |
| dlv_level | output | 1 | Trigger mode of the offered request (1 = level) |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector named by the EOI notice |

## Verification
The bench sweeps every line as an edge source and holds each line high well past its delivery. A line that re-fires while high, or a decoder that misplaces an entry, would show up as a wrong count or vector. Level lines are driven through the remote-pending cycle: a redundant delivery before EOI, an EOI with the wrong vector, and a drop-and-raise before EOI. Each of these must add no delivery, and a correct EOI must re-deliver. Masked edges, a pending edge cancelled by a mask write, and a level line EOI'd while masked probe the mask paths. A design that kept masked edges or lost masked levels would deliver too many or too few. Two simultaneous edges check that the lower line wins and the other follows on the next handshake.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic             mask;
        trig_e            trig;
        logic [2:0]       dmode;
        logic [VEC_W-1:0] vector;
    } redir_t;

    localparam redir_t ENTRY_RST = '{mask: 1'b1, trig: TRIG_EDGE, dmode: 3'd0, vector: '0};

    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_ARB   = 8'h02;
    localparam logic [7:0] IDX_TBL   = 8'h10;
    localparam logic [7:0] VER_CODE  = 8'h11;

    function automatic redir_t to_entry(input logic [31:0] w);
        redir_t e;
        e.vector = w[7:0];
        e.dmode  = w[10:8];
        e.trig   = trig_e'(w[15]);
        e.mask   = w[16];
        return e;
    endfunction

    function automatic logic [31:0] pack_low(input redir_t e, input logic pending);
        return {15'b0, e.mask, logic'(e.trig), pending, 3'b0, e.dmode, e.vector};
    endfunction

endpackage

// File: rtl/irq_line_slot.sv
module irq_line_slot
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  redir_t           wr_entry,
    input  logic             line_s,
    input  logic             line_rise,
    input  logic             grant,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    output redir_t           entry,
    output logic             rirr,
    output logic             want
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= ENTRY_RST;
            pend  <= 1'b0;
            rirr  <= 1'b0;
        end else begin
            if (wr_en)
                entry <= wr_entry;
            // edge request latch: consumed by a grant, set by an unmasked rise,
            // dropped by a write that masks the line or turns it into level
            if (grant)
                pend <= 1'b0;
            if (line_rise && entry.trig == TRIG_EDGE && !entry.mask)
                pend <= 1'b1;
            if (wr_en && (wr_entry.mask || wr_entry.trig == TRIG_LEVEL))
                pend <= 1'b0;
            // remote-pending flag: a level grant wins over a same-cycle EOI
            if (eoi_valid && eoi_vector == entry.vector)
                rirr <= 1'b0;
            if (grant && entry.trig == TRIG_LEVEL)
                rirr <= 1'b1;
        end
    end

    always_comb begin
        if (entry.trig == TRIG_EDGE)
            want = pend && !entry.mask;
        else
            want = line_s && !entry.mask && !rirr;
    end

    // R6: a level grant leaves the remote-pending flag set
    a_r6_rirr_set: assert property (@(posedge clk) disable iff (rst)
        grant && entry.trig == TRIG_LEVEL |=> rirr);

    // R5: an edge grant without a fresh rise empties the latch
    a_r5_edge_once: assert property (@(posedge clk) disable iff (rst)
        grant && entry.trig == TRIG_EDGE && !line_rise |=> !pend);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 24,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     want,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i])
                idx = IDX_W'(i);
        end
    end

    assign any = |want;

endmodule

// File: rtl/irq_reg_window.sv
module irq_reg_window
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int SLOT_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_sel,
    input  logic                 acc_wr,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    input  logic [31:0]          low_words [NUM_LINES],
    output logic [NUM_LINES-1:0] wr_low,
    output redir_t               wr_entry
);

    localparam int          TBL_END  = int'(IDX_TBL) + 2 * NUM_LINES;
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VER_CODE};

    logic [7:0]        idx_q;
    logic [3:0]        id_q;
    logic [3:0]        arb_q;
    logic [7:0]        off;
    logic              in_tbl;
    logic [SLOT_W-1:0] slot;
    logic              win_wr;
    logic              idx_wr;
    logic              id_wr;
    logic              wdata_unused;

    assign win_wr = acc_wr && acc_sel;
    assign idx_wr = acc_wr && !acc_sel;
    assign id_wr  = win_wr && idx_q == IDX_ID;
    assign off    = idx_q - IDX_TBL;
    assign in_tbl = int'(idx_q) >= int'(IDX_TBL) && int'(idx_q) < TBL_END;
    assign slot   = SLOT_W'(off >> 1);

    assign wdata_unused = ^{acc_wdata[31:28], acc_wdata[23:17], acc_wdata[14:11]};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
        end else begin
            if (idx_wr)
                idx_q <= acc_wdata[7:0];
            if (id_wr) begin
                id_q  <= acc_wdata[27:24];
                arb_q <= acc_wdata[27:24];
            end
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (!acc_sel)
            acc_rdata[7:0] = idx_q;
        else if (idx_q == IDX_ID)
            acc_rdata[27:24] = id_q;
        else if (idx_q == IDX_VER)
            acc_rdata = VER_WORD;
        else if (idx_q == IDX_ARB)
            acc_rdata[27:24] = arb_q;
        else if (in_tbl && !off[0])
            acc_rdata = low_words[slot];
    end

    assign wr_entry = to_entry(acc_wdata);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_wr
        assign wr_low[i] = win_wr && in_tbl && !off[0] && slot == SLOT_W'(i);
    end

    // R3: the arbitration value takes the ID write data
    a_r3_arb_follows_id: assert property (@(posedge clk) disable iff (rst)
        id_wr |=> arb_q == $past(acc_wdata[27:24]));

    // R3: nothing else moves the arbitration value
    a_r3_arb_hold: assert property (@(posedge clk) disable iff (rst)
        !id_wr |=> $stable(arb_q));

    // R4: at most one entry written per access
    a_r4_one_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_low));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 acc_sel,
    input  logic                 acc_wr,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    output logic                 dlv_valid,
    input  logic                 dlv_ready,
    output logic [VEC_W-1:0]     dlv_vector,
    output logic                 dlv_level,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector
);

    localparam int SLOT_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] line_s;
    logic [NUM_LINES-1:0] line_d;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] rirr_v;
    logic [NUM_LINES-1:0] want_v;
    logic [NUM_LINES-1:0] grant_v;
    logic [NUM_LINES-1:0] wr_low;
    logic [31:0]          low_words [NUM_LINES];
    redir_t               entries   [NUM_LINES];
    redir_t               wr_entry;
    logic [SLOT_W-1:0]    pick_idx;
    logic                 fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_s <= '0;
            line_d <= '0;
        end else begin
            line_s <= line_in;
            line_d <= line_s;
        end
    end

    assign rise = line_s & ~line_d;

    irq_reg_window #(.NUM_LINES(NUM_LINES)) u_win (
        .clk       (clk),
        .rst       (rst),
        .acc_sel   (acc_sel),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .low_words (low_words),
        .wr_low    (wr_low),
        .wr_entry  (wr_entry)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
        irq_line_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_low[i]),
            .wr_entry   (wr_entry),
            .line_s     (line_s[i]),
            .line_rise  (rise[i]),
            .grant      (grant_v[i]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .entry      (entries[i]),
            .rirr       (rirr_v[i]),
            .want       (want_v[i])
        );
        assign low_words[i] = pack_low(entries[i], rirr_v[i]);
        assign grant_v[i]   = fire && pick_idx == SLOT_W'(i);
    end

    irq_prio_pick #(.N(NUM_LINES), .IDX_W(SLOT_W)) u_pick (
        .want (want_v),
        .any  (dlv_valid),
        .idx  (pick_idx)
    );

    assign fire       = dlv_valid && dlv_ready;
    assign dlv_vector = entries[pick_idx].vector;
    assign dlv_level  = entries[pick_idx].trig == TRIG_LEVEL;

    // R11: the offered line is ready and no lower line is
    a_r11_lowest_first: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> want_v[pick_idx] &&
            ((want_v & ((NUM_LINES'(1) << pick_idx) - NUM_LINES'(1))) == '0));

    // R11: one grant per cycle at most
    a_r11_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_v));

    // R4: all lines leave reset masked, so nothing is offered
    a_r4_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dlv_valid);

endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] line_in = '0;
    logic        acc_sel = 1'b0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        dlv_valid;
    logic        dlv_ready = 1'b0;
    logic [7:0]  dlv_vector;
    logic        dlv_level;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int got_cnt;
    logic [7:0] got_vec [4];
    logic got_lvl;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    irq_router #(.NUM_LINES(N)) dut (
        .clk(clk), .rst(rst), .line_in(line_in),
        .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector), .dlv_level(dlv_level),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic sel, input logic [31:0] d);
        @(negedge clk);
        acc_sel = sel; acc_wr = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
        acc(1'b0, {24'b0, idx});
        acc(1'b1, d);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [31:0] v);
        acc(1'b0, {24'b0, idx});
        acc_sel = 1'b1;
        #1 v = acc_rdata;
    endtask

    task automatic prog(input int n, input logic [7:0] vec, input logic lvl, input logic msk);
        wr_reg(8'(8'h10 + 2 * n), {15'b0, msk, lvl, 7'b0, vec});
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        line_in[n] = v;
    endtask

    task automatic collect(input int cyc);
        got_cnt = 0;
        got_lvl = 1'b0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            dlv_ready = 1'b1;
            if (dlv_valid) begin
                if (got_cnt < 4) got_vec[got_cnt] = dlv_vector;
                got_lvl = dlv_level;
                got_cnt++;
            end
        end
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic idle(input int cyc);
        for (int c = 0; c < cyc; c++) @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // reset state
        check(dlv_valid == 1'b0, "R4 no request after reset", 32'(dlv_valid), 0);
        rd_reg(8'h00, rv); check(rv == 32'h0, "R1 ID reset", rv, 32'h0);
        rd_reg(8'h01, rv); check(rv == 32'h00170011, "R2 version value", rv, 32'h00170011);
        rd_reg(8'h02, rv); check(rv == 32'h0, "R3 arb reset", rv, 32'h0);
        for (int n = 0; n < N; n++) begin
            rd_reg(8'(8'h10 + 2 * n), rv);
            check(rv == 32'h00010000, "R4 entry reset masked", rv, 32'h00010000);
        end

        // R1, R3 identification and arbitration
        wr_reg(8'h00, 32'hFFFFFFFF);
        rd_reg(8'h00, rv); check(rv == 32'h0F000000, "R1 ID writable bits", rv, 32'h0F000000);
        rd_reg(8'h02, rv); check(rv == 32'h0F000000, "R3 arb follows ID", rv, 32'h0F000000);
        wr_reg(8'h02, 32'h0);
        rd_reg(8'h02, rv); check(rv == 32'h0F000000, "R3 arb write ignored", rv, 32'h0F000000);
        wr_reg(8'h00, 32'h05000000);
        rd_reg(8'h02, rv); check(rv == 32'h05000000, "R3 arb second ID write", rv, 32'h05000000);

        // R2 version read-only
        wr_reg(8'h01, 32'hFFFFFFFF);
        rd_reg(8'h01, rv); check(rv == 32'h00170011, "R2 version write ignored", rv, 32'h00170011);

        // R4 entry layout and index readback
        wr_reg(8'h1A, 32'hFFFFFFFF);
        rd_reg(8'h1A, rv); check(rv == 32'h000187FF, "R4 entry field layout", rv, 32'h000187FF);
        wr_reg(8'h1B, 32'hFFFFFFFF);
        rd_reg(8'h1B, rv); check(rv == 32'h0, "R4 high word zero", rv, 32'h0);
        acc_sel = 1'b0; #1;
        check(acc_rdata == 32'h1B, "R4 index readback", acc_rdata, 32'h1B);
        prog(5, 8'h00, 1'b0, 1'b1);

        // R5 edge sweep over every line
        for (int n = 0; n < N; n++) begin
            prog(n, 8'(8'h40 + n), 1'b0, 1'b0);
            set_line(n, 1'b1);
            collect(10);
            check(got_cnt == 1, "R5 edge one delivery", got_cnt, 1);
            check(got_vec[0] == 8'(8'h40 + n) && got_lvl == 1'b0, "R5 edge vector",
                  {23'b0, got_lvl, got_vec[0]}, 32'(8'h40 + n));
            set_line(n, 1'b0);
            collect(4);
            check(got_cnt == 0, "R5 falling edge silent", got_cnt, 0);
        end

        // R6 level delivery and remote-pending
        prog(14, 8'h77, 1'b1, 1'b0);
        set_line(14, 1'b1);
        collect(6);
        check(got_cnt == 1 && got_lvl == 1'b1, "R6 level one delivery", got_cnt, 1);
        collect(6);
        check(got_cnt == 0, "R6 blocked before EOI", got_cnt, 0);
        rd_reg(8'h2C, rv); check(rv == 32'h0000C077, "R6 remote-pending bit", rv, 32'h0000C077);

        // R7 EOI matching
        eoi(8'h55);
        collect(6);
        check(got_cnt == 0, "R7 wrong vector EOI", got_cnt, 0);
        eoi(8'h77);
        collect(6);
        check(got_cnt == 1 && got_vec[0] == 8'h77, "R7 redelivery after EOI", got_cnt, 1);

        // R8 coalescing
        set_line(14, 1'b0);
        set_line(14, 1'b1);
        collect(6);
        check(got_cnt == 0, "R8 reassert coalesced", got_cnt, 0);
        eoi(8'h77);
        collect(6);
        check(got_cnt == 1, "R8 single delivery after EOI", got_cnt, 1);
        set_line(14, 1'b0);
        eoi(8'h77);
        collect(6);
        check(got_cnt == 0, "R7 low line after EOI", got_cnt, 0);
        rd_reg(8'h2C, rv); check(rv == 32'h00008077, "R7 remote-pending cleared", rv, 32'h00008077);

        // R9 masked edge discarded
        prog(14, 8'h81, 1'b0, 1'b1);
        set_line(14, 1'b1);
        set_line(14, 1'b0);
        collect(6);
        check(got_cnt == 0, "R9 masked edge", got_cnt, 0);
        prog(14, 8'h81, 1'b0, 1'b0);
        collect(6);
        check(got_cnt == 0, "R9 no delivery on unmask", got_cnt, 0);
        set_line(14, 1'b1);
        collect(6);
        check(got_cnt == 1, "R9 later edge delivered", got_cnt, 1);
        set_line(14, 1'b0);

        // R9 mask write cancels a pending edge
        prog(3, 8'h33, 1'b0, 1'b0);
        set_line(3, 1'b1);
        set_line(3, 1'b0);
        idle(3);
        check(dlv_valid == 1'b1, "R9 edge pending before mask", 32'(dlv_valid), 1);
        prog(3, 8'h33, 1'b0, 1'b1);
        prog(3, 8'h33, 1'b0, 1'b0);
        collect(6);
        check(got_cnt == 0, "R9 pending edge cancelled", got_cnt, 0);

        // R10 masked level stays pending
        prog(14, 8'h82, 1'b1, 1'b1);
        set_line(14, 1'b1);
        collect(6);
        check(got_cnt == 0, "R10 masked level held", got_cnt, 0);
        prog(14, 8'h82, 1'b1, 1'b0);
        collect(6);
        check(got_cnt == 1 && got_vec[0] == 8'h82, "R10 delivered on unmask", got_cnt, 1);
        prog(14, 8'h82, 1'b1, 1'b1);
        eoi(8'h82);
        collect(6);
        check(got_cnt == 0, "R10 masked after EOI", got_cnt, 0);
        prog(14, 8'h82, 1'b1, 1'b0);
        collect(6);
        check(got_cnt == 1, "R10 unmask after EOI", got_cnt, 1);
        set_line(14, 1'b0);
        eoi(8'h82);
        prog(14, 8'h82, 1'b1, 1'b1);

        // R11 priority between simultaneous edges
        prog(3, 8'h33, 1'b0, 1'b0);
        prog(9, 8'h99, 1'b0, 1'b0);
        @(negedge clk);
        line_in[3] = 1'b1; line_in[9] = 1'b1;
        @(negedge clk);
        line_in[3] = 1'b0; line_in[9] = 1'b0;
        idle(3);
        check(dlv_valid && dlv_vector == 8'h33, "R11 lowest offered first", {24'b0, dlv_vector}, 32'h33);
        collect(6);
        check(got_cnt == 2, "R11 both delivered", got_cnt, 2);
        check(got_vec[0] == 8'h33 && got_vec[1] == 8'h99, "R11 delivery order",
              {16'b0, got_vec[0], got_vec[1]}, 32'h3399);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule